// File: doc/BRIEF.md
# UART Receiver with Stale-Data Interrupt

This block is a single asynchronous serial receive channel. A 16x oversample enable from outside paces it. It checks each start bit at mid-bit, shifts in eight data bits with the least significant bit first, and checks one stop bit. Each good character goes into a 16-entry receive FIFO. A host on a small byte-wide bus sees three addresses: a status register, a data port that pops one byte on each read, and a command register.

The interrupt is not raised for every byte. It is raised when the FIFO becomes full. It is also raised when at least one byte has sat unread for 64 bit times, so a single keystroke is never left stranded. The interrupt is a level and holds while either cause holds.

For flow control, RTS drops when a new start bit is validated while the FIFO is full. If that character still completes, an overrun flag is set, the character is lost, and reception stays blocked until a clear command is written.

Top module: `uart_rx_stale`

## Requirements
- R1: A frame is 8N1: a low start bit, eight data bits with the LSB first, and a high stop bit. Each bit is sampled at its middle using the 16x enable `os_tick`. A frame whose stop bit samples low is discarded.
- R2: A low on `rxd` lasting less than half a bit time is ignored and starts no frame.
- R3: Up to 16 bytes are held in arrival order. Status bit 0 (read at address 0) is 1 while the FIFO holds at least one byte. A read of address 1 pops one byte. Read data appears on `rdata` in the cycle after the read strobe.
- R4: `irq` is asserted once the FIFO holds 16 bytes. Status bit 1 is 1 while the FIFO is full.
- R5: `irq` is asserted when the FIFO is not empty and no byte has been written into or popped from it for 64 bit times (64*16 `os_tick` pulses). The watchdog restarts on every write and every pop, and it stays cleared while the FIFO is empty.
- R6: `irq` is a level. It drops once the FIFO is below full and the watchdog condition no longer holds.
- R7: `rts` (1 = ready to receive) goes to 0 when a start bit is validated while the FIFO is full.
- R8: A character that completes while the FIFO is full sets the overrun flag (status bit 4) and is dropped. While the flag is set, every later character is dropped as well.
- R9: Writing 0x40 to address 2 clears the overrun flag. Any other value written there has no effect on it.
- R10: `rts` returns to 1 only once the FIFO has a free entry and no overrun is pending.
- R11: After reset, `rts` is 1, `irq` is 0 and the status register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| cs | input | 1 | Bus access strobe |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 2 | 0 status, 1 data, 2 command |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after the strobe |
| irq | output | 1 | Level receive interrupt |
| rts | output | 1 | Ready-to-receive flow-control output |

## Verification
The hardest state to reach from the ports is an overrun: the FIFO must be full, a start bit must be held long enough to be validated, and then the rest of that frame must complete. The bench fills the FIFO with sixteen back-to-back frames without reading any of them. It then drives a start bit by hand, checks that RTS drops partway through that bit, and finishes the frame to set the flag. With the flag set, it sends one more frame, writes a non-clearing command, pops one byte, and only then writes the clear command. This shows that both conditions gate RTS and that no dropped byte leaks into the FIFO. The stale watchdog is checked on either side of its 64-bit-time boundary with a single byte in the FIFO.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_WAIT_HI
  } rx_state_e;

  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_DATA   = 2'd1;
  localparam logic [1:0] ADDR_CMD    = 2'd2;
endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          rxd_i,
  output logic          start_seen_o,
  output logic          byte_valid_o,
  output logic [DW-1:0] data_o
);
  localparam int CW = $clog2(OSR);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(OSR - 1);
  localparam logic [CW-1:0] CNT_MID  = CW'(OSR / 2 - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(DW - 1);

  logic [1:0]    sync_q;
  logic          rxd_s;
  rx_state_e     st_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] bit_q;
  logic [DW-1:0] sh_q;

  assign rxd_s = sync_q[1];

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], rxd_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= RX_IDLE;
      cnt_q        <= '0;
      bit_q        <= '0;
      sh_q         <= '0;
      start_seen_o <= 1'b0;
      byte_valid_o <= 1'b0;
    end else begin
      start_seen_o <= 1'b0;
      byte_valid_o <= 1'b0;
      if (tick_i) begin
        case (st_q)
          RX_IDLE: begin
            if (!rxd_s) begin
              st_q  <= RX_START;
              cnt_q <= '0;
            end
          end
          RX_START: begin
            if (cnt_q == CNT_MID) begin
              cnt_q <= '0;
              if (!rxd_s) begin
                st_q         <= RX_DATA;
                bit_q        <= '0;
                start_seen_o <= 1'b1;
              end else begin
                st_q <= RX_IDLE;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_DATA: begin
            if (cnt_q == CNT_LAST) begin
              cnt_q <= '0;
              sh_q  <= {rxd_s, sh_q[DW-1:1]};
              if (bit_q == BIT_LAST) st_q <= RX_STOP;
              else                   bit_q <= bit_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt_q == CNT_LAST) begin
              cnt_q <= '0;
              if (rxd_s) begin
                byte_valid_o <= 1'b1;
                st_q         <= RX_IDLE;
              end else begin
                st_q <= RX_WAIT_HI;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: begin
            if (rxd_s) st_q <= RX_IDLE;
          end
        endcase
      end
    end
  end

  assign data_o = sh_q;

  // R1: a frame start and a frame end never coincide
  a_r1_single_event: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_seen_o, byte_valid_o}));
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] dout_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] CNT_FULL = (AW+1)'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          push_ok, pop_ok;

  assign full_o  = (cnt_q == CNT_FULL);
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= din_i;
    if (pop_ok)  dout_o    <= mem[rp_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wp_q <= wp_q + 1'b1;
      if (pop_ok)  rp_q <= rp_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R3: a push into a full FIFO without a pop leaves the occupancy unchanged
  a_r3_no_overfill: assert property (@(posedge clk) disable iff (rst)
    (push_i && full_o && !pop_i) |=> $stable(cnt_q));
endmodule

// File: rtl/uart_rx_stale_timer.sv
module uart_rx_stale_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic empty_i,
  input  logic restart_i,
  output logic stale_o
);
  localparam int TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] T_LAST = TW'(LIMIT - 1);

  logic [TW-1:0] t_q;

  always_ff @(posedge clk) begin
    if (rst || empty_i || restart_i) begin
      t_q     <= '0;
      stale_o <= 1'b0;
    end else if (tick_i && !stale_o) begin
      t_q <= t_q + 1'b1;
      if (t_q == T_LAST) stale_o <= 1'b1;
    end
  end

  // R5: nothing is stale once the FIFO has emptied
  a_r5_clear_when_empty: assert property (@(posedge clk) disable iff (rst)
    empty_i |=> (!stale_o && t_q == '0));
endmodule

// File: rtl/uart_rx_stale.sv
module uart_rx_stale
  import uart_rx_pkg::*;
#(
  parameter int         OSR        = 16,
  parameter int         DW         = 8,
  parameter int         DEPTH      = 16,
  parameter int         STALE_BITS = 64,
  parameter logic [7:0] CMD_CLR_OVR = 8'h40
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       os_tick,
  input  logic       rxd,
  input  logic       cs,
  input  logic       we,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       rts
);
  localparam int STALE_TICKS = STALE_BITS * OSR;

  logic          start_seen, byte_valid;
  logic [DW-1:0] rx_byte, fifo_dout;
  logic          fifo_full, fifo_empty, fifo_push, fifo_pop;
  logic          stale;
  logic          ovr_q, rts_q, irq_q;
  logic          rd_req, wr_req, clr_cmd;
  logic [1:0]    rsel_q;
  logic [7:0]    status_q;

  assign rd_req  = cs && !we;
  assign wr_req  = cs && we;
  assign clr_cmd = wr_req && (addr == ADDR_CMD) && (wdata == CMD_CLR_OVR);
  assign fifo_pop  = rd_req && (addr == ADDR_DATA) && !fifo_empty;
  assign fifo_push = byte_valid && !fifo_full && !ovr_q;

  uart_rx_deser #(.OSR(OSR), .DW(DW)) deser_i (
    .clk(clk), .rst(rst), .tick_i(os_tick), .rxd_i(rxd),
    .start_seen_o(start_seen), .byte_valid_o(byte_valid), .data_o(rx_byte)
  );

  uart_rx_fifo #(.DW(DW), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst(rst), .push_i(fifo_push), .din_i(rx_byte),
    .pop_i(fifo_pop), .dout_o(fifo_dout), .full_o(fifo_full),
    .empty_o(fifo_empty)
  );

  uart_rx_stale_timer #(.LIMIT(STALE_TICKS)) timer_i (
    .clk(clk), .rst(rst), .tick_i(os_tick), .empty_i(fifo_empty),
    .restart_i(fifo_push || fifo_pop), .stale_o(stale)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_q    <= 1'b0;
      rts_q    <= 1'b1;
      irq_q    <= 1'b0;
      rsel_q   <= ADDR_STATUS;
      status_q <= '0;
    end else begin
      if (byte_valid && fifo_full) ovr_q <= 1'b1;
      else if (clr_cmd)            ovr_q <= 1'b0;

      if (!fifo_full && !ovr_q)           rts_q <= 1'b1;
      else if (start_seen || ovr_q)       rts_q <= 1'b0;

      irq_q <= fifo_full || stale;

      if (rd_req) begin
        rsel_q   <= addr;
        status_q <= {3'b000, ovr_q, 2'b00, fifo_full, !fifo_empty};
      end
    end
  end

  always_comb begin
    case (rsel_q)
      ADDR_STATUS: rdata = status_q;
      ADDR_DATA:   rdata = 8'(fifo_dout);
      default:     rdata = '0;
    endcase
  end

  assign irq = irq_q;
  assign rts = rts_q;

  // R4: a full FIFO raises the interrupt on the next cycle
  a_r4_irq_on_full: assert property (@(posedge clk) disable iff (rst)
    fifo_full |=> irq_q);
  // R7: a validated start bit against a full FIFO drops RTS
  a_r7_rts_drop: assert property (@(posedge clk) disable iff (rst)
    (start_seen && fifo_full) |=> !rts_q);
  // R10: no RTS while an overrun is pending
  a_r10_rts_ovr: assert property (@(posedge clk) disable iff (rst)
    ovr_q |=> !rts_q);
  // R8: the overrun flag only falls through the clear command
  a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && !clr_cmd) |=> ovr_q);
endmodule

// File: tb/uart_rx_stale_tb_top.sv
module uart_rx_stale_tb_top;
  localparam int TICK_DIV = 4;
  localparam int BITCLK   = 16 * TICK_DIV;
  localparam int NVEC     = 8;
  // stimulus byte in [15:8], expected read-back in [7:0]
  localparam logic [15:0] VEC [NVEC] = '{
    16'h5555, 16'hA3A3, 16'h0000, 16'hFFFF,
    16'h0101, 16'h8080, 16'h3C3C, 16'hC3C3
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       os_tick = 1'b0;
  logic       rxd = 1'b1;
  logic       cs = 1'b0, we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq, rts;
  int         checks = 0, errors = 0;
  bit         done = 0;

  uart_rx_stale dut_i (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd), .cs(cs), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .rts(rts)
  );

  always #5 clk = ~clk;

  initial begin
    forever begin
      repeat (TICK_DIV - 1) @(negedge clk);
      os_tick = 1'b1;
      @(negedge clk);
      os_tick = 1'b0;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); cs = 1'b0; d = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); cs = 1'b0; we = 1'b0;
  endtask

  task automatic send_tail(input logic [7:0] b, input logic stopv);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (BITCLK) @(negedge clk);
    end
    rxd = stopv;
    repeat (BITCLK) @(negedge clk);
    rxd = 1'b1;
    repeat (BITCLK / 2) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic stopv);
    rxd = 1'b0;
    repeat (BITCLK) @(negedge clk);
    send_tail(b, stopv);
  endtask

  initial begin
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    check("R11 rts", {7'd0, rts}, 8'd1);
    check("R11 irq", {7'd0, irq}, 8'd0);
    rd(2'd0, d); check("R11 status", d, 8'h00);

    // R1 R3 table of frames
    for (int v = 0; v < NVEC; v++) begin
      send_byte(VEC[v][15:8], 1'b1);
      rd(2'd0, d); check("R3 ready", d & 8'h01, 8'h01);
      rd(2'd1, d); check("R1 data", d, VEC[v][7:0]);
      rd(2'd0, d); check("R3 drained", d & 8'h01, 8'h00);
    end

    // R2 glitch shorter than half a bit
    rxd = 1'b0; repeat (4 * TICK_DIV) @(negedge clk); rxd = 1'b1;
    repeat (12 * BITCLK) @(negedge clk);
    rd(2'd0, d); check("R2 glitch ignored", d, 8'h00);
    // R5 empty FIFO never raises the watchdog
    check("R5 empty no irq", {7'd0, irq}, 8'd0);

    // R1 framing error discards the frame
    send_byte(8'h77, 1'b0);
    repeat (BITCLK) @(negedge clk);
    rd(2'd0, d); check("R1 bad stop dropped", d, 8'h00);

    // R5 R6 stale-data watchdog
    send_byte(8'h42, 1'b1);
    repeat (3900) @(negedge clk);
    check("R5 before limit", {7'd0, irq}, 8'd0);
    repeat (300) @(negedge clk);
    check("R5 stale irq", {7'd0, irq}, 8'd1);
    rd(2'd1, d); check("R5 stale data", d, 8'h42);
    repeat (3) @(negedge clk);
    check("R6 irq drops", {7'd0, irq}, 8'd0);

    // R4 fill the FIFO
    for (int i = 0; i < 16; i++) send_byte(8'(i * 17 + 3), 1'b1);
    check("R4 irq full", {7'd0, irq}, 8'd1);
    rd(2'd0, d); check("R4 status full", d, 8'h03);
    check("R10 rts before start", {7'd0, rts}, 8'd1);

    // R7 start bit against full FIFO
    rxd = 1'b0;
    repeat (48) @(negedge clk);
    check("R7 rts drop", {7'd0, rts}, 8'd0);
    repeat (BITCLK - 48) @(negedge clk);
    send_tail(8'hEE, 1'b1);
    rd(2'd0, d); check("R8 overrun set", d, 8'h13);
    send_byte(8'hDD, 1'b1);

    // R9 other command does nothing
    wr(2'd2, 8'h10);
    rd(2'd0, d); check("R9 other cmd", d & 8'h10, 8'h10);

    rd(2'd1, d); check("R8 first kept", d, 8'd3);
    repeat (3) @(negedge clk);
    check("R10 rts held by overrun", {7'd0, rts}, 8'd0);
    rd(2'd0, d); check("R8 still blocked", d, 8'h11);

    wr(2'd2, 8'h40);
    rd(2'd0, d); check("R9 cleared", d, 8'h01);
    repeat (2) @(negedge clk);
    check("R10 rts back", {7'd0, rts}, 8'd1);

    for (int i = 1; i < 16; i++) begin
      rd(2'd1, d); check("R8 order no dropped byte", d, 8'(i * 17 + 3));
    end
    rd(2'd0, d); check("R8 empty after drain", d, 8'h00);
    repeat (3) @(negedge clk);
    check("R6 irq low after drain", {7'd0, irq}, 8'd0);

    send_byte(8'h5A, 1'b1);
    rd(2'd1, d); check("R9 reception resumes", d, 8'h5A);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R0 watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule